// File: doc/BRIEF.md
# BCD Calendar with Update Freeze

This block keeps the time of day and the calendar date in binary-coded decimal. It counts hundredths of a second, seconds, minutes, hours in 24-hour form, day of week, day of month, month and a two-digit year, plus a century bit. A free-running tick enable drives a prescaler. Every `DIV_TICKS` ticks the prescaler produces one hundredth-of-a-second step, and the step ripples through the whole chain. Month lengths and leap Februaries are handled in hardware.

Two copies of the time exist. The running copy advances. The user copy is what the register port returns. The user copy reloads from the running copy every cycle unless updates are frozen. Updates freeze while the bus port points at one of the eight clock registers, so a multi-byte read sees a consistent snapshot. They also freeze while a halt flag is set. A power-fail pulse sets the halt flag, which keeps the power-down moment visible until software clears the flag.

A write to a clock register loads the field into both copies and restarts the sub-second prescaler, so the new time starts counting from a clean boundary. A stop bit in the seconds register holds the running copy still.

Top module: `bcdcal_top`

## Requirements
- R1: After reset the registers read: 00h hundredths=00, 01h seconds=00, 02h minutes=00, 03h hours=00, 04h day=1, 05h date=01, 06h month=01, 07h year=00, 08h=00. The century, century-enable, stop and halt bits are all 0.
- R2: Hundredths count 00..99, seconds 00..59, minutes 00..59 and hours 00..23, in BCD. Each field wraps to 00 and carries into the next. One hundredth step happens on every `DIV_TICKS`-th cycle with `tick_en` high. The step appears on `bus_rdata` after the second rising edge that follows that tick cycle.
- R3: Day of week sits in bits 2:0 of 04h. It advances at the midnight carry and goes from 7 back to 1.
- R4: At the midnight carry, the date returns to 01 when it equals the month length. Otherwise it increments. Months 04, 06, 09 and 11 have 30 days. February has 29 days when the year is a multiple of 4 and 28 days otherwise. All other months have 31.
- R5: Month wraps from 12 to 01 and carries into the year. The year wraps from 99 to 00.
- R6: In 03h, bit 7 is the century enable and bit 6 is the century bit, and bits 5:0 hold the hours. When the year wraps and the enable is 1, the century bit inverts. When the enable is 0, the century bit holds.
- R7: Bit 7 of 01h is the stop bit. While it is 1, no field advances. Once it is cleared, counting resumes, and the first step comes `DIV_TICKS` ticks after the clearing write.
- R8: While `bus_sel` is high and `bus_addr` is in 00h..07h, the user copy does not reload. It reloads again after deselect, or while the pointer is outside that range.
- R9: A write (`bus_sel` and `bus_wr` both high) to 00h..07h loads that field into both copies and empties the prescaler. Ticks counted before the write are discarded. A tick in the same cycle as the write produces no step.
- R10: Bit 0 of 08h is the halt bit. A `power_fail` pulse sets it. While it is set, the user copy does not reload. Writing 0 to it clears it. When a `power_fail` pulse and a clearing write fall in the same cycle, the bit stays set.
- R11: `bus_rdata` shows the user copy at `bus_addr`. The stop bit and century enable read back live. 08h returns the halt bit in bit 0, and every address from 09h to 3Fh returns 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 1 | Prescaler tick enable, one cycle per tick |
| power_fail | input | 1 | Power-fail pulse that sets the halt bit |
| bus_sel | input | 1 | Register port selected (access in progress) |
| bus_addr | input | ADDR_W | Register pointer |
| bus_wr | input | 1 | Write strobe, valid with bus_sel |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data from the user copy |

## Verification
Two pairs of events can collide in one cycle. The first pair is a prescaler tick that completes a hundredth and a bus write to a clock field. The bench raises `tick_en` and the write strobe on the same edge when the prescaler is one tick short of a step. It then expects the written seconds value, an unchanged hundredths value, and a prescaler that needs a full `DIV_TICKS` further ticks. The second pair is a `power_fail` pulse and a write that clears the halt bit. The bench drives both together and expects the halt bit to read back as 1.

// File: rtl/bcdcal_pkg.sv
package bcdcal_pkg;

    localparam int NUM_CLK_REGS = 8;

    typedef struct packed {
        logic [7:0] hund;
        logic [7:0] sec;
        logic [7:0] min;
        logic [7:0] hour;
        logic [7:0] dow;
        logic [7:0] date;
        logic [7:0] month;
        logic [7:0] year;
        logic       cent;
    } cal_time_t;

    typedef enum logic [2:0] {
        IDX_HUND  = 3'd0,
        IDX_SEC   = 3'd1,
        IDX_MIN   = 3'd2,
        IDX_HOUR  = 3'd3,
        IDX_DOW   = 3'd4,
        IDX_DATE  = 3'd5,
        IDX_MONTH = 3'd6,
        IDX_YEAR  = 3'd7
    } cal_idx_e;

    localparam cal_time_t CAL_RESET = '{
        hund: 8'h00, sec: 8'h00, min: 8'h00, hour: 8'h00,
        dow: 8'h01, date: 8'h01, month: 8'h01, year: 8'h00, cent: 1'b0
    };

    // Two-digit BCD increment; callers handle the wrap value themselves.
    function automatic logic [7:0] bcd_inc(input logic [7:0] v);
        if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
        else                return {v[7:4], v[3:0] + 4'd1};
    endfunction

    // 10*t + o is a multiple of 4 exactly when 2*t + o is.
    function automatic logic bcd_leap(input logic [7:0] y);
        logic [4:0] s;
        s = {y[7:4], 1'b0} + {1'b0, y[3:0]};
        return (s[1:0] == 2'b00);
    endfunction

    function automatic logic [7:0] month_len(input logic [7:0] m, input logic [7:0] y);
        case (m)
            8'h02:                      return bcd_leap(y) ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
            default:                    return 8'h31;
        endcase
    endfunction

    // Load one bus byte into the matching time field, masking unused bits.
    function automatic cal_time_t put_field(input cal_time_t t, input cal_idx_e idx,
                                            input logic [7:0] d);
        cal_time_t r;
        r = t;
        case (idx)
            IDX_HUND:  r.hund  = d;
            IDX_SEC:   r.sec   = {1'b0, d[6:0]};
            IDX_MIN:   r.min   = {1'b0, d[6:0]};
            IDX_HOUR:  begin r.hour = {2'b00, d[5:0]}; r.cent = d[6]; end
            IDX_DOW:   r.dow   = {5'b0, d[2:0]};
            IDX_DATE:  r.date  = {2'b00, d[5:0]};
            IDX_MONTH: r.month = {3'b000, d[4:0]};
            IDX_YEAR:  r.year  = d;
            default:   r = t;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/cal_divider.sv
module cal_divider #(
    parameter int DIV_TICKS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic clr_i,
    input  logic hold_i,
    output logic adv_o
);
    localparam int CW = (DIV_TICKS > 1) ? $clog2(DIV_TICKS) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV_TICKS - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } div_state_t;

    div_state_t st_d, st_q;

    always_comb begin
        st_d  = st_q;
        adv_o = 1'b0;
        if (clr_i || hold_i) begin
            st_d.cnt = '0;
        end else if (tick_i) begin
            if (st_q.cnt == LAST) begin
                st_d.cnt = '0;
                adv_o    = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R9: a clock write leaves the prescaler empty on the next cycle
    p_clear_empties_r9: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (st_q.cnt == '0));

endmodule

// File: rtl/cal_running.sv
module cal_running
    import bcdcal_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       adv_i,
    input  logic       wr_i,
    input  cal_idx_e   wr_idx_i,
    input  logic [7:0] wdata_i,
    output cal_time_t  run_o,
    output logic       stop_o,
    output logic       ceb_o
);
    typedef struct packed {
        cal_time_t t;
        logic      stop;
        logic      ceb;
    } run_state_t;

    run_state_t s_d, s_q;
    logic c_sec, c_min, c_hour, c_day, c_mon, c_year, c_cent;
    logic [7:0] mlen;

    always_comb begin
        s_d    = s_q;
        mlen   = month_len(s_q.t.month, s_q.t.year);
        c_sec  = 1'b0;
        c_min  = 1'b0;
        c_hour = 1'b0;
        c_day  = 1'b0;
        c_mon  = 1'b0;
        c_year = 1'b0;
        c_cent = 1'b0;
        if (wr_i) begin
            s_d.t = put_field(s_q.t, wr_idx_i, wdata_i);
            if (wr_idx_i == IDX_SEC)  s_d.stop = wdata_i[7];
            if (wr_idx_i == IDX_HOUR) s_d.ceb  = wdata_i[7];
        end else if (adv_i && !s_q.stop) begin
            c_sec  = (s_q.t.hund == 8'h99);
            c_min  = c_sec  && (s_q.t.sec   == 8'h59);
            c_hour = c_min  && (s_q.t.min   == 8'h59);
            c_day  = c_hour && (s_q.t.hour  == 8'h23);
            c_mon  = c_day  && (s_q.t.date  == mlen);
            c_year = c_mon  && (s_q.t.month == 8'h12);
            c_cent = c_year && (s_q.t.year  == 8'h99);

            s_d.t.hund = c_sec ? 8'h00 : bcd_inc(s_q.t.hund);
            if (c_sec)  s_d.t.sec  = c_min  ? 8'h00 : bcd_inc(s_q.t.sec);
            if (c_min)  s_d.t.min  = c_hour ? 8'h00 : bcd_inc(s_q.t.min);
            if (c_hour) s_d.t.hour = c_day  ? 8'h00 : bcd_inc(s_q.t.hour);
            if (c_day) begin
                s_d.t.dow  = (s_q.t.dow == 8'h07) ? 8'h01 : bcd_inc(s_q.t.dow);
                s_d.t.date = c_mon ? 8'h01 : bcd_inc(s_q.t.date);
            end
            if (c_mon)  s_d.t.month = c_year ? 8'h01 : bcd_inc(s_q.t.month);
            if (c_year) s_d.t.year  = c_cent ? 8'h00 : bcd_inc(s_q.t.year);
            if (c_cent && s_q.ceb) s_d.t.cent = ~s_q.t.cent;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{t: CAL_RESET, stop: 1'b0, ceb: 1'b0};
        else        s_q <= s_d;
    end

    assign run_o  = s_q.t;
    assign stop_o = s_q.stop;
    assign ceb_o  = s_q.ceb;

    // R7: with the stop bit set, only a bus write can change the running time
    p_stopped_static_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.stop && !wr_i) |=> $stable(s_q.t));

    // R6: with the century enable clear, the century bit moves only by a write
    p_century_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!s_q.ceb && !wr_i) |=> $stable(s_q.t.cent));

endmodule

// File: rtl/cal_user.sv
module cal_user
    import bcdcal_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  cal_time_t  run_i,
    input  logic       acc_freeze_i,
    input  logic       wr_i,
    input  cal_idx_e   wr_idx_i,
    input  logic [7:0] wdata_i,
    input  logic       halt_wr_i,
    input  logic       halt_wdata_i,
    input  logic       power_fail_i,
    output cal_time_t  usr_o,
    output logic       halt_o
);
    typedef struct packed {
        cal_time_t t;
        logic      halt;
    } usr_state_t;

    usr_state_t s_d, s_q;
    logic freeze;

    always_comb begin
        s_d    = s_q;
        freeze = acc_freeze_i || s_q.halt;
        // the power-fail set takes priority over a clearing write
        if (power_fail_i)   s_d.halt = 1'b1;
        else if (halt_wr_i) s_d.halt = halt_wdata_i;
        if (wr_i)           s_d.t = put_field(s_q.t, wr_idx_i, wdata_i);
        else if (!freeze)   s_d.t = run_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{t: CAL_RESET, halt: 1'b0};
        else        s_q <= s_d;
    end

    assign usr_o  = s_q.t;
    assign halt_o = s_q.halt;

    // R8: an access to the clock registers freezes the visible copy
    p_access_freeze_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_freeze_i && !wr_i) |=> $stable(s_q.t));

    // R10: a power-fail pulse always leaves the halt bit set
    p_halt_after_fail_r10: assert property (@(posedge clk) disable iff (!rst_n)
        power_fail_i |=> s_q.halt);

    // R10: while halted the visible copy holds the power-down time
    p_halt_holds_copy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.halt && !wr_i) |=> $stable(s_q.t));

endmodule

// File: rtl/bcdcal_top.sv
module bcdcal_top
    import bcdcal_pkg::*;
#(
    parameter int DIV_TICKS = 4,
    parameter int ADDR_W    = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              power_fail,
    input  logic              bus_sel,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata
);
    localparam logic [ADDR_W-1:0] CLK_END   = ADDR_W'(NUM_CLK_REGS);
    localparam logic [ADDR_W-1:0] HALT_ADDR = ADDR_W'(NUM_CLK_REGS);

    logic      in_clk_range, clk_wr, halt_wr, adv;
    logic      run_stop, run_ceb, usr_halt;
    cal_idx_e  wr_idx;
    cal_time_t run_t, usr_t;

    assign in_clk_range = bus_sel && (bus_addr < CLK_END);
    assign clk_wr       = in_clk_range && bus_wr;
    assign halt_wr      = bus_sel && bus_wr && (bus_addr == HALT_ADDR);
    assign wr_idx       = cal_idx_e'(bus_addr[2:0]);

    cal_divider #(.DIV_TICKS(DIV_TICKS)) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_i (tick_en),
        .clr_i  (clk_wr),
        .hold_i (run_stop),
        .adv_o  (adv)
    );

    cal_running u_run (
        .clk      (clk),
        .rst_n    (rst_n),
        .adv_i    (adv),
        .wr_i     (clk_wr),
        .wr_idx_i (wr_idx),
        .wdata_i  (bus_wdata),
        .run_o    (run_t),
        .stop_o   (run_stop),
        .ceb_o    (run_ceb)
    );

    cal_user u_usr (
        .clk          (clk),
        .rst_n        (rst_n),
        .run_i        (run_t),
        .acc_freeze_i (in_clk_range),
        .wr_i         (clk_wr),
        .wr_idx_i     (wr_idx),
        .wdata_i      (bus_wdata),
        .halt_wr_i    (halt_wr),
        .halt_wdata_i (bus_wdata[0]),
        .power_fail_i (power_fail),
        .usr_o        (usr_t),
        .halt_o       (usr_halt)
    );

    always_comb begin
        bus_rdata = 8'h00;
        if (bus_addr < CLK_END) begin
            case (wr_idx)
                IDX_HUND:  bus_rdata = usr_t.hund;
                IDX_SEC:   bus_rdata = {run_stop, usr_t.sec[6:0]};
                IDX_MIN:   bus_rdata = usr_t.min;
                IDX_HOUR:  bus_rdata = {run_ceb, usr_t.cent, usr_t.hour[5:0]};
                IDX_DOW:   bus_rdata = usr_t.dow;
                IDX_DATE:  bus_rdata = usr_t.date;
                IDX_MONTH: bus_rdata = usr_t.month;
                IDX_YEAR:  bus_rdata = usr_t.year;
                default:   bus_rdata = 8'h00;
            endcase
        end else if (bus_addr == HALT_ADDR) begin
            bus_rdata = {7'b0, usr_halt};
        end
    end

    // R11: addresses above the halt register always read as zero
    p_unused_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr > HALT_ADDR) |-> (bus_rdata == 8'h00));

endmodule

// File: tb/bcdcal_top_tb.sv
module bcdcal_top_tb;
    localparam int DIV = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_en = 1'b0;
    logic       power_fail = 1'b0;
    logic       bus_sel = 1'b0;
    logic [5:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;

    int n_checks = 0;
    int n_err = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    bcdcal_top #(.DIV_TICKS(DIV), .ADDR_W(6)) u_dut (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .power_fail(power_fail),
        .bus_sel(bus_sel), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    function automatic logic [7:0] bcd(input int v);
        return 8'((v / 10) * 16 + (v % 10));
    endfunction

    function automatic int days_of(input int m, input int y);
        if (m == 2) return (y % 4 == 0) ? 29 : 28;
        if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
        return 31;
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_addr = a; bus_wr = 1'b1; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic desel();
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic settle();
        repeat (2) @(negedge clk);
    endtask

    task automatic rd(input logic [5:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick_en = 1'b1;
            @(negedge clk); tick_en = 1'b0;
        end
    endtask

    task automatic set_time(input logic [7:0] h, s, m, hr, dw, dt, mo, yr);
        wr(6'h00, h);  wr(6'h01, s);  wr(6'h02, m);  wr(6'h03, hr);
        wr(6'h04, dw); wr(6'h05, dt); wr(6'h06, mo); wr(6'h07, yr);
        desel();
        settle();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
            $finish;
        end
    end

    initial begin
        logic [7:0] v, v2, v3;
        logic [7:0] rst_exp [0:8];
        rst_exp = '{8'h00, 8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00, 8'h00};
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset contents; R11: unused address reads zero
        for (int a = 0; a < 9; a++) begin
            rd(6'(a), v);
            check("R1 reset value", v, rst_exp[a]);
        end
        rd(6'h20, v);
        check("R11 unused address", v, 8'h00);
        desel();

        // R2: hundredths sweep with carry into seconds
        for (int h = 0; h < 100; h++) begin
            set_time(bcd(h), 8'h30, 8'h10, 8'h05, 8'h02, 8'h10, 8'h05, 8'h21);
            ticks(DIV); settle();
            rd(6'h00, v); rd(6'h01, v2);
            check("R2 hundredths step", v, bcd((h + 1) % 100));
            check("R2 seconds carry", v2, (h == 99) ? 8'h31 : 8'h30);
            desel();
        end
        // R2: seconds sweep
        for (int s = 0; s < 60; s++) begin
            set_time(8'h99, bcd(s), 8'h10, 8'h05, 8'h02, 8'h10, 8'h05, 8'h21);
            ticks(DIV); settle();
            rd(6'h01, v); rd(6'h02, v2);
            check("R2 seconds step", v, bcd((s + 1) % 60));
            check("R2 minutes carry", v2, (s == 59) ? 8'h11 : 8'h10);
            desel();
        end
        // R2: minutes sweep
        for (int m = 0; m < 60; m++) begin
            set_time(8'h99, 8'h59, bcd(m), 8'h05, 8'h02, 8'h10, 8'h05, 8'h21);
            ticks(DIV); settle();
            rd(6'h02, v); rd(6'h03, v2);
            check("R2 minutes step", v, bcd((m + 1) % 60));
            check("R2 hours carry", v2, (m == 59) ? 8'h06 : 8'h05);
            desel();
        end
        // R2: hours sweep
        for (int hr = 0; hr < 24; hr++) begin
            set_time(8'h99, 8'h59, 8'h59, bcd(hr), 8'h02, 8'h10, 8'h05, 8'h21);
            ticks(DIV); settle();
            rd(6'h03, v); rd(6'h05, v2);
            check("R2 hours step", v, bcd((hr + 1) % 24));
            check("R2 date carry", v2, (hr == 23) ? 8'h11 : 8'h10);
            desel();
        end

        // R3: day of week 7 wraps to 1
        for (int d = 1; d <= 7; d++) begin
            set_time(8'h99, 8'h59, 8'h59, 8'h23, bcd(d), 8'h10, 8'h05, 8'h21);
            ticks(DIV); settle();
            rd(6'h04, v);
            check("R3 day of week", v, bcd((d == 7) ? 1 : d + 1));
            desel();
        end

        // R4 and R5: last day of every month across all years
        for (int y = 0; y < 100; y++) begin
            for (int m = 1; m <= 12; m++) begin
                set_time(8'h99, 8'h59, 8'h59, 8'h23, 8'h03, bcd(days_of(m, y)), bcd(m), bcd(y));
                ticks(DIV); settle();
                rd(6'h05, v); rd(6'h06, v2); rd(6'h07, v3);
                check("R4 date wraps to 01", v, 8'h01);
                check("R5 month advance", v2, bcd((m == 12) ? 1 : m + 1));
                check("R5 year advance", v3, (m == 12) ? bcd((y + 1) % 100) : bcd(y));
                desel();
            end
            // R4: Feb 28 stays in February only in a leap year
            set_time(8'h99, 8'h59, 8'h59, 8'h23, 8'h03, 8'h28, 8'h02, bcd(y));
            ticks(DIV); settle();
            rd(6'h05, v); rd(6'h06, v2);
            check("R4 leap February date", v, (y % 4 == 0) ? 8'h29 : 8'h01);
            check("R4 leap February month", v2, (y % 4 == 0) ? 8'h02 : 8'h03);
            desel();
        end

        // R6: century toggles with the enable set, holds with it clear
        set_time(8'h99, 8'h59, 8'h59, 8'h80 | 8'h23, 8'h03, 8'h31, 8'h12, 8'h99);
        ticks(DIV); settle();
        rd(6'h03, v);
        check("R6 century toggles", v, 8'hC0);
        desel();
        set_time(8'h99, 8'h59, 8'h59, 8'h40 | 8'h23, 8'h03, 8'h31, 8'h12, 8'h99);
        ticks(DIV); settle();
        rd(6'h03, v);
        check("R6 century holds", v, 8'h40);
        desel();

        // R7: stop bit halts, clearing resumes after DIV ticks
        set_time(8'h50, 8'h92, 8'h00, 8'h01, 8'h01, 8'h01, 8'h01, 8'h10);
        ticks(3 * DIV); settle();
        rd(6'h00, v); rd(6'h01, v2);
        check("R7 stopped hundredths", v, 8'h50);
        check("R7 stop bit readback", v2, 8'h92);
        wr(6'h01, 8'h12); desel();
        ticks(DIV - 1); settle();
        rd(6'h00, v);
        check("R7 no step before DIV ticks", v, 8'h50);
        desel();
        ticks(1); settle();
        rd(6'h00, v);
        check("R7 resumed", v, 8'h51);
        desel();

        // R8: freeze while pointing into the clock range
        set_time(8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h01, 8'h10);
        @(negedge clk); bus_sel = 1'b1; bus_addr = 6'h02;
        ticks(2 * DIV); settle();
        rd(6'h00, v);
        check("R8 frozen during access", v, 8'h00);
        desel(); settle();
        rd(6'h00, v);
        check("R8 reload after deselect", v, 8'h02);
        @(negedge clk); bus_addr = 6'h10;
        ticks(DIV);
        rd(6'h00, v);
        check("R8 reload outside clock range", v, 8'h03);
        desel();

        // R9: clock write empties the prescaler
        set_time(8'h40, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h01, 8'h10);
        ticks(DIV - 1);
        wr(6'h00, 8'h40); desel();
        ticks(DIV - 1); settle();
        rd(6'h00, v);
        check("R9 earlier ticks discarded", v, 8'h40);
        desel();
        ticks(1); settle();
        rd(6'h00, v);
        check("R9 step after full count", v, 8'h41);
        desel();
        // R9: tick and write in the same cycle
        wr(6'h00, 8'h99); desel();
        ticks(DIV - 1);
        @(negedge clk);
        bus_sel = 1'b1; bus_addr = 6'h01; bus_wr = 1'b1; bus_wdata = 8'h20; tick_en = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; tick_en = 1'b0;
        desel(); settle();
        rd(6'h00, v); rd(6'h01, v2);
        check("R9 collision no step", v, 8'h99);
        check("R9 collision write wins", v2, 8'h20);
        desel();
        ticks(DIV - 1); settle();
        rd(6'h00, v);
        check("R9 prescaler restarted", v, 8'h99);
        desel();

        // R10: halt on power fail, priority over clearing write
        set_time(8'h10, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h01, 8'h10);
        @(negedge clk); power_fail = 1'b1;
        @(negedge clk); power_fail = 1'b0;
        rd(6'h08, v);
        check("R10 halt set", v, 8'h01);
        desel();
        ticks(2 * DIV); settle();
        rd(6'h00, v);
        check("R10 frozen at power-down", v, 8'h10);
        @(negedge clk);
        bus_sel = 1'b1; bus_addr = 6'h08; bus_wr = 1'b1; bus_wdata = 8'h00; power_fail = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; power_fail = 1'b0;
        rd(6'h08, v);
        check("R10 power fail beats clear", v, 8'h01);
        wr(6'h08, 8'h00); desel(); settle();
        rd(6'h08, v);
        check("R10 halt cleared", v, 8'h00);
        rd(6'h00, v);
        check("R10 copy resumes", v, 8'h12);
        rd(6'h09, v);
        check("R11 address 09h zero", v, 8'h00);
        rd(6'h3F, v);
        check("R11 address 3Fh zero", v, 8'h00);
        desel();

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end
endmodule